// File: doc/BRIEF.md
# Multi-Bank Interleaved Word Memory with Open-Page Timing

This block is a word-addressable storage array split into several independent banks. The lowest address bits choose the bank, so a run of consecutive addresses visits every bank in rotation. Each bank models a DRAM-style array. It keeps one page open in a row buffer. An access to the open page takes one memory cycle. An access to any other page in that bank first spends a configurable number of cycles loading the new page.

Requests enter through a valid/ready port that carries the address, a write enable, write data and a tag. Ready depends only on the bank that the current address selects. A bank that is loading a page therefore stalls only the requests aimed at it, and requests to other banks keep flowing. Reads return their data and tag on a single registered response port. When several banks finish in the same cycle, the responses leave one per cycle with the lowest bank index first. Writes produce no response.

With the default parameters (4 banks, 10-bit address, 3 column bits), address bits [1:0] select the bank, bits [4:2] are the column inside a page and bits [9:5] are the page number.

Top module: `bank_mem_top`

## Requirements
- R1: The bank of word address a is a mod NUM_BANKS, taken from the low address bits. Each address holds its own word, and a read returns the data most recently written to that exact address.
- R2: Consecutive addresses fall in successive banks. A stream of requests that rotates through banks whose pages are open is accepted on consecutive cycles.
- R3: After reset req_ready is 1, rsp_valid is 0 and every row buffer is empty, so the first access to any bank takes the page-load path.
- R4: A read accepted in cycle c whose page is open in its bank shows rsp_valid with the data and tag in cycle c+2. This is one memory cycle plus the output register.
- R5: A read accepted in cycle c whose page is not open shows its response in cycle c+2+LOAD_CYC. req_ready for that bank is 0 in cycles c+1 through c+LOAD_CYC.
- R6: A bank that is loading a page does not delay other banks. They accept requests and answer open-page reads with R4 timing.
- R7: A write stores the data and leaves its page open in the row buffer, just as a read does. It never raises rsp_valid.
- R8: Reads that complete in the same cycle leave through the single response port one per cycle, lowest bank index first. Each response carries the tag of its own request.
- R9: req_ready reflects only the bank selected by req_addr, whether or not req_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Request tag, returned with read data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W | Read data |
| rsp_tag | output | TAG_W | Tag of the answered read |

## Verification
The bench covers several corner cases. It checks the first access after reset and the switch to a new page within one bank. A design that treats an empty row buffer as a hit, or that charges the wrong load time, answers early or late. It watches req_ready cycle by cycle while one bank loads and another bank is addressed, to catch a stall that leaks across banks or a bank that releases early. It forces a loading bank and an open-page bank to finish in the same cycle, so a design that orders responses by issue, or that drops or mixes up a tag, returns the wrong tag first. A write-then-read on a fresh page checks that writes both open the page and stay silent on the response port.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  typedef enum logic {
    BK_IDLE = 1'b0,
    BK_LOAD = 1'b1
  } bk_state_e;
endpackage

// File: rtl/bmem_bank.sv
module bmem_bank
  import bmem_pkg::*;
#(
  parameter int LOC_W    = 8,
  parameter int COL_W    = 3,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  parameter int LOAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              grant_i,
  output logic              ready_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [TAG_W-1:0]  rtag_o
);
  localparam int PAGE_W = LOC_W - COL_W;
  localparam int DEPTH  = 1 << LOC_W;
  localparam int CNT_W  = $clog2(LOAD_CYC + 1);

  bk_state_e             state;
  logic [CNT_W-1:0]      cnt;
  logic                  open_v;
  logic [PAGE_W-1:0]     open_pg;
  logic                  s_we;
  logic [LOC_W-1:0]      s_loc;
  logic [DATA_W-1:0]     s_wd;
  logic [TAG_W-1:0]      s_tag;
  logic [DATA_W-1:0]     mem [DEPTH];
  logic [DATA_W-1:0]     rd_q;

  logic                  hit, busy, do_now, do_late, mem_do, mem_we;
  logic [LOC_W-1:0]      mem_a;
  logic [DATA_W-1:0]     mem_wd;
  logic [TAG_W-1:0]      mem_tag;

  always_comb begin
    hit     = open_v && (open_pg == loc_i[LOC_W-1:COL_W]);
    busy    = (state == BK_LOAD);
    ready_o = !busy && (!pend_o || grant_i);
    do_now  = acc_i && hit;
    do_late = busy && (cnt == '0);
    mem_do  = do_now || do_late;
    mem_we  = do_now ? we_i    : s_we;
    mem_a   = do_now ? loc_i   : s_loc;
    mem_wd  = do_now ? wdata_i : s_wd;
    mem_tag = do_now ? tag_i   : s_tag;
  end

  // Single-port array, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (mem_do) begin
      if (mem_we) mem[mem_a] <= mem_wd;
      else        rd_q       <= mem[mem_a];
    end
  end
  assign rdata_o = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BK_IDLE;
      cnt     <= '0;
      open_v  <= 1'b0;
      open_pg <= '0;
      s_we    <= 1'b0;
      s_loc   <= '0;
      s_wd    <= '0;
      s_tag   <= '0;
      pend_o  <= 1'b0;
      rtag_o  <= '0;
    end else begin
      if (acc_i && !hit) begin
        state <= BK_LOAD;
        cnt   <= CNT_W'(LOAD_CYC - 1);
        s_we  <= we_i;
        s_loc <= loc_i;
        s_wd  <= wdata_i;
        s_tag <= tag_i;
      end else if (busy) begin
        if (cnt == '0) begin
          state   <= BK_IDLE;
          open_v  <= 1'b1;
          open_pg <= s_loc[LOC_W-1:COL_W];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (mem_do && !mem_we) begin
        pend_o <= 1'b1;
        rtag_o <= mem_tag;
      end else if (grant_i) begin
        pend_o <= 1'b0;
      end
    end
  end

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !hit) |=> !ready_o);  // R5
  AST_LOAD_SPAN: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);  // R5
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !grant_i && !busy) |=> (pend_o && $stable(rtag_o)));  // R8
endmodule

// File: rtl/bmem_rsp_arb.sv
module bmem_rsp_arb #(
  parameter int NB     = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NB-1:0]        pend_i,
  input  logic [NB*DATA_W-1:0] data_i,
  input  logic [NB*TAG_W-1:0]  tag_i,
  output logic [NB-1:0]        grant_o,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_data_o,
  output logic [TAG_W-1:0]     rsp_tag_o
);
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1;

  logic [SEL_W-1:0] sel;
  logic             found;

  always_comb begin
    grant_o = '0;
    sel     = '0;
    found   = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (pend_i[i] && !found) begin
        grant_o[i] = 1'b1;
        sel        = SEL_W'(i);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_tag_o   <= '0;
    end else begin
      rsp_valid_o <= found;
      rsp_data_o  <= data_i[sel*DATA_W +: DATA_W];
      rsp_tag_o   <= tag_i[sel*TAG_W +: TAG_W];
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));  // R8
  AST_PEND_TO_RSP: assert property (@(posedge clk) disable iff (rst)
    (|pend_i) |=> rsp_valid_o);  // R8
endmodule

// File: rtl/bank_mem_top.sv
module bank_mem_top #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 10,
  parameter int COL_W     = 3,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int LOAD_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int LOC_W  = ADDR_W - BANK_W;

  logic [BANK_W-1:0]           bank_sel;
  logic [LOC_W-1:0]            loc;
  logic [NUM_BANKS-1:0]        bank_ready, acc_vec, pend, grant;
  logic [NUM_BANKS*DATA_W-1:0] bank_data;
  logic [NUM_BANKS*TAG_W-1:0]  bank_tag;

  assign bank_sel  = req_addr[BANK_W-1:0];
  assign loc       = req_addr[ADDR_W-1:BANK_W];
  assign req_ready = bank_ready[bank_sel];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign acc_vec[b] = req_valid && req_ready && (bank_sel == BANK_W'(b));
    bmem_bank #(
      .LOC_W(LOC_W), .COL_W(COL_W), .DATA_W(DATA_W),
      .TAG_W(TAG_W), .LOAD_CYC(LOAD_CYC)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .acc_i   (acc_vec[b]),
      .we_i    (req_we),
      .loc_i   (loc),
      .wdata_i (req_wdata),
      .tag_i   (req_tag),
      .grant_i (grant[b]),
      .ready_o (bank_ready[b]),
      .pend_o  (pend[b]),
      .rdata_o (bank_data[b*DATA_W +: DATA_W]),
      .rtag_o  (bank_tag[b*TAG_W +: TAG_W])
    );
  end

  bmem_rsp_arb #(.NB(NUM_BANKS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend),
    .data_i      (bank_data),
    .tag_i       (bank_tag),
    .grant_o     (grant),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .rsp_tag_o   (rsp_tag)
  );

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc_vec));  // R1
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_we && (pend == '0)) |=> !(|pend));  // R7
endmodule

// File: tb/sim_bank_mem_top.sv
`timescale 1ns/1ps
module sim_bank_mem_top;
  localparam int LOAD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_addr = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_tag = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [3:0]  rsp_tag;

  always #5 clk = ~clk;

  bank_mem_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_tag(rsp_tag)
  );

  typedef struct { logic [3:0] tag; logic [15:0] data; int cyc; string req; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0, rsp_cnt = 0;
  int seen_cyc [16];
  logic [15:0] mm [1024];
  int  opg [4];
  bit  ov  [4];
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: match responses against expected items
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      bit hitq;
      hitq = 1'b0;
      rsp_cnt++;
      seen_cyc[rsp_tag] = cyc;
      for (int i = 0; i < q.size(); i++) begin
        if (!hitq && q[i].tag == rsp_tag) begin
          hitq = 1'b1;
          chk(rsp_data == q[i].data, q[i].req, "read data", int'(rsp_data), int'(q[i].data));
          if (q[i].cyc >= 0)
            chk(cyc == q[i].cyc, q[i].req, "response cycle", cyc, q[i].cyc);
          q.delete(i);
        end
      end
      if (!hitq) chk(1'b0, "R7", "unexpected response tag", int'(rsp_tag), -1);
    end
  end

  task automatic send(input int a, input bit we, input logic [15:0] d,
                      input logic [3:0] t, input bit tchk, input string req,
                      output int acc);
    int b, pg, lat;
    exp_t e;
    b  = a % 4;
    pg = a / 32;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 10'(a); req_we = we; req_wdata = d; req_tag = t;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    acc = cyc;
    req_valid = 1'b0;
    lat = (ov[b] && opg[b] == pg) ? 1 : 1 + LOAD;
    ov[b] = 1'b1; opg[b] = pg;
    if (we) mm[a] = d;
    else begin
      e.tag = t; e.data = mm[a]; e.cyc = tchk ? acc + lat : -1; e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic drain(input string req);
    int w = 0;
    while (q.size() != 0 && w < 2000) begin @(negedge clk); w++; end
    chk(q.size() == 0, req, "pending responses drained", q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, a1, a9, a10, a12, a13;
    for (int i = 0; i < 4; i++) begin ov[i] = 1'b0; opg[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R3", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R3", "rsp_valid after reset", int'(rsp_valid), 0);

    // R7: writes, no responses; R6: bank1 not held by loading bank0
    send(32, 1, 16'h1032, 0, 0, "R7", a0);
    send(34, 1, 16'h1034, 0, 0, "R7", a0);
    send(64, 1, 16'h1064, 0, 0, "R7", a0);
    send(0, 1, 16'hA000, 0, 0, "R7", a0);
    send(1, 1, 16'hA001, 0, 0, "R6", a1);
    chk(a1 == a0 + 1, "R6", "bank1 accepted while bank0 loads", a1 - a0, 1);
    for (int i = 2; i < 8; i++) send(i, 1, 16'hA000 + 16'(i), 0, 0, "R1", a0);
    repeat (12) @(negedge clk);
    chk(rsp_cnt == 0, "R7", "writes give no response", rsp_cnt, 0);

    // R4/R2/R1: open-page reads rotating through banks (pages opened by writes)
    for (int i = 0; i < 4; i++) begin
      int ac, prev;
      send(i, 0, 0, 4'(i), 1, "R4", ac);
      if (i > 0) chk(ac == prev + 1, "R2", "rotating reads back to back", ac - prev, 1);
      prev = ac;
    end
    for (int i = 4; i < 8; i++) send(i, 0, 0, 4'(i), 1, "R1", a0);
    drain("R4");

    // R5: page conflict in bank0, ready watched per bank (R9)
    send(32, 0, 0, 4'd8, 1, "R5", a0);
    for (int k = 1; k <= LOAD; k++) begin
      @(negedge clk); req_addr = 10'd0; #1;
      chk(req_ready == 1'b0, "R5", "bank0 stalled during load", int'(req_ready), 0);
      req_addr = 10'd1; #1;
      chk(req_ready == 1'b1, "R9", "bank1 ready while bank0 loads", int'(req_ready), 1);
    end
    @(negedge clk); req_addr = 10'd0; #1;
    chk(req_ready == 1'b1, "R5", "bank0 ready after load", int'(req_ready), 1);
    drain("R5");

    // R6: open-page read in bank1 not delayed by bank0 conflict
    send(64, 0, 0, 4'd9, 1, "R5", a9);
    send(1, 0, 0, 4'd10, 1, "R6", a10);
    chk(a10 == a9 + 1, "R6", "bank1 read accepted next cycle", a10 - a9, 1);
    drain("R6");

    // R7: write on new page opens it; read is a hit
    send(97, 1, 16'h5A97, 0, 0, "R7", a0);
    send(97, 0, 0, 4'd11, 1, "R7", a0);
    drain("R7");

    // R8: bank2 load finishes together with bank1 hit; bank1 first
    send(34, 0, 0, 4'd12, 0, "R8", a12);
    repeat (LOAD - 1) @(posedge clk);
    send(97, 0, 0, 4'd13, 0, "R8", a13);
    chk(a13 == a12 + LOAD, "R8", "hit accepted in completion cycle", a13 - a12, LOAD);
    drain("R8");
    chk(seen_cyc[13] == a12 + LOAD + 1, "R8", "lower bank answered first",
        seen_cyc[13] - a12, LOAD + 1);
    chk(seen_cyc[12] == a12 + LOAD + 2, "R8", "higher bank answered next",
        seen_cyc[12] - a12, LOAD + 2);

    // R1: sweep of writes then reads across two pages per bank
    for (int i = 128; i < 192; i++) send(i, 1, 16'(i * 37 + 5), 0, 0, "R1", a0);
    for (int blk = 0; blk < 4; blk++) begin
      for (int i = 0; i < 16; i++)
        send(128 + blk * 16 + i, 0, 0, 4'(i), 0, "R1", a0);
      drain("R1");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule